// File: doc/BRIEF.md
# Clock Buffer Power-Up Sequencer

This block brings a clock fan-out buffer from an unpowered state to running outputs in a fixed order. It follows four inputs: a comparator that flags a valid supply, an active-low power-down request, a detector that reports a usable input clock, and the lock flag of the buffer's PLL. From these it drives a one-cycle strobe that captures the configuration straps, the PLL enable, and a single enable that gates every clock output.

A rising supply-valid starts the sequence. The machine captures the straps, then waits a fixed settling window counted on a free-running reference clock. It then stays pending until power-down is released, the input clock is good and the PLL reports lock. All three must hold for a set number of consecutive cycles before the outputs open. If power-down is requested, the input clock is lost or lock drops, the outputs close at once and the machine goes back to pending. If the supply flag falls, the machine returns to off without waiting for a clock edge. The PLL settling time of the application sets `SETTLE_CYCLES`. It must fit inside the latency budget allowed between a good input clock and active outputs.

Top module: `clkbuf_pwrup_seq`

## Requirements
- R1: `seq_state` encodes off = 0, delay = 1, pending = 2, run = 3. While `rst_n` or `supply_ok` is low, the state is off and both `out_en` and `pll_en` are low.
- R2: In the off state with `rst_n` and `supply_ok` high, `strap_stb` is high. At the next clock edge the state becomes delay and `strap_q` takes the value of `strap_in`.
- R3: The delay state lasts exactly `DLY_CYCLES` clock edges and then moves to pending. `pd_n`, `clk_ok` and `pll_lock` do not affect it, and `pll_en` stays low during it.
- R4: `pll_en` is high exactly when the state is pending or run and `pd_n` is high.
- R5: The machine moves from pending to run after `SETTLE_CYCLES` consecutive edges in which `pd_n`, `clk_ok` and `pll_lock` are all high. Any edge where one of them is low restarts that count from zero.
- R6: `out_en` is high only in the run state, and only while `pd_n`, `clk_ok` and `pll_lock` are all high. It drops in the same cycle that any of them falls.
- R7: In the run state, an edge with `pd_n`, `clk_ok` or `pll_lock` low moves the machine to pending.
- R8: A falling `supply_ok` forces the state to off at once, with no clock edge needed.
- R9: `strap_q` changes only at an edge where `strap_stb` is high. At all other times it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above threshold; its fall forces off asynchronously |
| pd_n | input | 1 | Active-low power-down request |
| clk_ok | input | 1 | Input clock detected as valid |
| pll_lock | input | 1 | PLL lock indication |
| strap_in | input | STRAP_W | Configuration strap pins |
| strap_stb | output | 1 | Strap capture strobe |
| strap_q | output | STRAP_W | Captured strap value |
| pll_en | output | 1 | PLL enable |
| out_en | output | 1 | Master enable for all clock outputs |
| seq_state | output | 2 | Current sequencer state |

## Verification
On every cycle, the assertions check several properties. Each output-enable rise must come after a fully qualified cycle. The strobe never lasts more than one cycle. The PLL stays off while the machine is in delay. A run state facing a lost qualifier drops back to pending. The delay window never runs past its length. The bench's scenarios are needed to show the rest: the exact length of the delay and settle windows, the restart of the settle count after a short break, the capture of the strap value, and the asynchronous fall to off when the supply drops between clock edges.

// File: rtl/clkbuf_pwrup_seq.sv
module clkbuf_pwrup_seq #(
  parameter int DLY_CYCLES    = 64,
  parameter int SETTLE_CYCLES = 32,
  parameter int STRAP_W       = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               supply_ok,
  input  logic               pd_n,
  input  logic               clk_ok,
  input  logic               pll_lock,
  input  logic [STRAP_W-1:0] strap_in,
  output logic               strap_stb,
  output logic [STRAP_W-1:0] strap_q,
  output logic               pll_en,
  output logic               out_en,
  output logic [1:0]         seq_state
);

  localparam int MAXC  = (DLY_CYCLES > SETTLE_CYCLES) ? DLY_CYCLES : SETTLE_CYCLES;
  localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DLY_CYCLES - 1);
  localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_CYCLES - 1);

  typedef enum logic [1:0] {S_OFF = 2'd0, S_DLY = 2'd1, S_PEND = 2'd2, S_RUN = 2'd3} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             qual;

  assign qual      = pd_n && clk_ok && pll_lock;
  assign strap_stb = rst_n && supply_ok && (st == S_OFF);
  assign pll_en    = ((st == S_PEND) || (st == S_RUN)) && pd_n;
  assign out_en    = (st == S_RUN) && qual;
  assign seq_state = st;

  always_ff @(posedge clk or negedge rst_n or negedge supply_ok) begin
    if (!rst_n || !supply_ok) begin
      st  <= S_OFF;
      cnt <= '0;
    end else begin
      case (st)
        S_OFF: begin
          st  <= S_DLY;
          cnt <= '0;
        end
        S_DLY: begin
          if (cnt == DLY_LAST) begin
            st  <= S_PEND;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PEND: begin
          if (!qual) begin
            cnt <= '0;
          end else if (cnt == SET_LAST) begin
            st  <= S_RUN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (!qual) st <= S_PEND;
          cnt <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         strap_q <= '0;
    else if (strap_stb) strap_q <= strap_in;
  end

  logic [CNT_W:0] chk_dly;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            chk_dly <= '0;
    else if (st == S_DLY)  chk_dly <= chk_dly + 1'b1;
    else                   chk_dly <= '0;
  end

  a_r6_open_after_qual: assert property (@(posedge clk) disable iff (!rst_n || !supply_ok)
    $rose(out_en) |-> ($past(pll_lock) && $past(clk_ok) && $past(pd_n)));

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n || !supply_ok)
    strap_stb |=> !strap_stb);

  a_r3_pll_off_in_delay: assert property (@(posedge clk) disable iff (!rst_n || !supply_ok)
    (seq_state == 2'd1) |-> !pll_en);

  a_r3_delay_bounded: assert property (@(posedge clk) disable iff (!rst_n || !supply_ok)
    (st == S_DLY) |-> (chk_dly < (CNT_W+1)'(DLY_CYCLES)));

  a_r7_run_drops: assert property (@(posedge clk) disable iff (!rst_n || !supply_ok)
    ((seq_state == 2'd3) && !(pd_n && clk_ok && pll_lock)) |=> (seq_state == 2'd2));

  a_r5_run_entry: assert property (@(posedge clk) disable iff (!rst_n || !supply_ok)
    (seq_state == 2'd3) |-> ($past(seq_state) == 2'd3 || $past(seq_state) == 2'd2));

endmodule

// File: tb/clkbuf_pwrup_seq_tb.sv
`timescale 1ns/1ps
module clkbuf_pwrup_seq_tb;
  localparam int DLY = 64;
  localparam int SET = 32;
  localparam int SW  = 3;

  logic clk = 1'b0;
  logic rst_n, supply_ok, pd_n, clk_ok, pll_lock;
  logic [SW-1:0] strap_in;
  logic strap_stb, pll_en, out_en;
  logic [SW-1:0] strap_q;
  logic [1:0] seq_state;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_st = 0, m_cnt = 0;
  logic [SW-1:0] m_strap = '0;

  always #2 clk = ~clk;

  clkbuf_pwrup_seq #(.DLY_CYCLES(DLY), .SETTLE_CYCLES(SET), .STRAP_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pd_n(pd_n), .clk_ok(clk_ok),
    .pll_lock(pll_lock), .strap_in(strap_in), .strap_stb(strap_stb), .strap_q(strap_q),
    .pll_en(pll_en), .out_en(out_en), .seq_state(seq_state));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit q_now();
    return pd_n && clk_ok && pll_lock;
  endfunction

  task automatic model_edge();
    if (!rst_n || !supply_ok) begin m_st = 0; m_cnt = 0; end
    else case (m_st)
      0: begin m_strap = strap_in; m_st = 1; m_cnt = 0; end
      1: if (m_cnt == DLY-1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
      2: if (!q_now()) m_cnt = 0;
         else if (m_cnt == SET-1) begin m_st = 3; m_cnt = 0; end
         else m_cnt++;
      default: if (!q_now()) m_st = 2;
    endcase
  endtask

  task automatic compare();
    chk("R5 state", int'(seq_state), m_st);
    chk("R6 out_en", int'(out_en), int'(m_st == 3 && q_now()));
    chk("R4 pll_en", int'(pll_en), int'(m_st >= 2 && pd_n));
    chk("R2 strap_stb", int'(strap_stb), int'(rst_n && supply_ok && m_st == 0));
    chk("R9 strap_q", int'(strap_q), int'(m_strap));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic supply_drop();
    supply_ok = 1'b0;
    #1;
    m_st = 0; m_cnt = 0;
    chk("R8 async off", int'(seq_state), 0);
    chk("R1 out_en off", int'(out_en), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt_d;
    int seed;
    seed = $urandom(32'd2024);
    rst_n = 0; supply_ok = 0; pd_n = 0; clk_ok = 0; pll_lock = 0; strap_in = '0;
    repeat (3) step();
    chk("R1 reset state", int'(seq_state), 0);
    chk("R1 reset pll_en", int'(pll_en), 0);
    rst_n = 1;
    step();
    chk("R1 off without supply", int'(seq_state), 0);

    supply_ok = 1; strap_in = 3'd5; pd_n = 1; clk_ok = 1; pll_lock = 1;
    #1;
    chk("R2 strobe in off", int'(strap_stb), 1);
    step();
    chk("R2 enter delay", int'(seq_state), 1);
    chk("R2 strap captured", int'(strap_q), 5);
    strap_in = 3'd2;
    cnt_d = 0;
    while (seq_state == 2'd1 && cnt_d < 1000) begin step(); cnt_d++; end
    chk("R3 delay length", cnt_d, DLY);
    chk("R9 strap held", int'(strap_q), 5);

    repeat (10) step();
    pll_lock = 0; step();
    pll_lock = 1;
    cnt_d = 0;
    while (seq_state == 2'd2 && cnt_d < 1000) begin step(); cnt_d++; end
    chk("R5 settle after restart", cnt_d, SET);
    chk("R6 out_en in run", int'(out_en), 1);

    pd_n = 0; #1;
    chk("R6 out_en drops at once", int'(out_en), 0);
    chk("R4 pll off on power-down", int'(pll_en), 0);
    step();
    chk("R7 back to pending", int'(seq_state), 2);
    pd_n = 1;
    repeat (SET + 2) step();
    clk_ok = 0; step();
    chk("R7 clock loss to pending", int'(seq_state), 2);
    clk_ok = 1;

    for (int i = 0; i < 5000; i++) begin
      if (supply_ok && ($urandom % 400) == 0) supply_drop();
      else if (!supply_ok && ($urandom % 6) == 0) supply_ok = 1;
      if (($urandom % 60) == 0) pd_n = ~pd_n;
      if (($urandom % 80) == 0) clk_ok = ~clk_ok;
      if (($urandom % 25) == 0) pll_lock = ~pll_lock;
      strap_in = SW'($urandom);
      step();
    end

    supply_ok = 1; pd_n = 1; clk_ok = 1; pll_lock = 1;
    repeat (DLY + SET + 4) step();
    chk("R6 run reached", int'(out_en), 1);
    supply_drop();
    step();
    chk("R8 stays off", int'(seq_state), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule